// File: doc/BRIEF.md
# Event-Gated Performance Counter Unit

This block measures how often chosen events occur while a shared measurement window is open. It has a set of independent counters. Each counter picks one line of an event vector through its own select code. A window controller opens and closes counting for all counters together. The window follows one of three start/stop pairings: program start until break, condition 1 until condition 2, or condition 2 until condition 1.

Events on the branch line add two per occurrence. A counter that would pass its maximum stops at all ones and raises a sticky overflow flag. An initialize command clears every count and flag. Counting advances only while the core clock enable is high, so a stopped clock (for example during sleep) freezes all state. Software reads the results through a small address-decoded read port.

Top module: `perf_count_unit`

## Requirements
- R1: Each of the NCH counters selects an event line with its own SELW-bit code. Code k in 1..NEV selects `events[k-1]`. Code 0, or any code above NEV, counts nothing.
- R2: With `mode` = 0, a `run_start` pulse opens the window and a `brk` pulse closes it. Both the opening cycle and the closing cycle are counted.
- R3: With `mode` = 1, `cond1` opens the window and `cond2` closes it. A `cond2` while the window is closed has no effect.
- R4: With `mode` = 2, `cond2` opens the window and `cond1` closes it. A `cond1` while the window is closed has no effect.
- R5: Code 1 selects the branch line `events[0]`, and each hit on it adds 2. Every other valid code adds 1 per hit.
- R6: When an addition would pass 2^CW-1, the counter holds all ones and its overflow flag sets. The flag stays set and the value stays at all ones until initialize.
- R7: While `clk_en` is low, no counter changes and the window state does not change, whatever the events and conditions do.
- R8: Reset and `init` clear all counters, overflow flags, the window and the configuration error. `init` takes priority over counting in the same cycle.
- R9: A start condition that arrives while no counter has a valid code sets the sticky configuration error flag and leaves the window closed.
- R10: A start and an end condition in the same cycle count that one cycle only, and the window is closed afterwards.
- R11: Read address i < NCH returns counter i. Address NCH returns the flag word: bits NCH-1..0 are the overflow flags, bit NCH is window open, bit NCH+1 is the configuration error. Any other address returns 0.
- R12: With `mode` = 3, the window never opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Core clock running; low freezes all counting state |
| init | input | 1 | Clears all results and flags |
| mode | input | 2 | Window mode: 0 run/break, 1 cond1→cond2, 2 cond2→cond1, 3 off |
| run_start | input | 1 | Program execution start pulse |
| brk | input | 1 | Break pulse |
| cond1 | input | 1 | Break condition 1 match |
| cond2 | input | 1 | Break condition 2 match |
| events | input | NEV | Event lines, bit 0 is the branch event |
| sel | input | NCH*SELW | Per-counter select codes, counter i in slice i |
| rd_addr | input | RAW | Read address |
| rd_data | output | CW | Read data (combinational) |

## Verification
The bench builds the unit with CW = 8, NEV = 6 and the default four counters. The 8-bit width lets saturation and the sticky overflow flag be reached in about 128 branch hits, instead of billions of cycles. NEV = 6 leaves select code 7 unused, so an out-of-range code can be checked. The bench runs each window mode, the coincident start/stop case, the clock freeze, and initialize during an open window. It reads every result back through the read port.

// File: rtl/pcu_pkg.sv
// Package: shared encodings for the performance counter unit.
// Assumes: window mode is a 2-bit field; the branch line is selected by code 1.
package pcu_pkg;
    typedef enum logic [1:0] {
        WIN_RUN  = 2'd0,
        WIN_C1C2 = 2'd1,
        WIN_C2C1 = 2'd2,
        WIN_OFF  = 2'd3
    } win_mode_e;

    localparam int unsigned BRANCH_CODE = 1;
endpackage

// File: rtl/pcu_window.sv
// Module: measurement window controller.
// Maps the selected mode onto start/stop strobes and keeps the open state.
// A start with no valid channel raises a sticky configuration error.
// Assumes: strobes are single-cycle and sampled only while clk_en is high.
module pcu_window
    import pcu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_en,
    input  logic       init,
    input  logic [1:0] mode,
    input  logic       run_start,
    input  logic       brk,
    input  logic       cond1,
    input  logic       cond2,
    input  logic       any_sel,
    output logic       count_en,
    output logic       win_open,
    output logic       cfg_err
);
    logic start_raw, stop_raw, start_ok;
    logic open_q, err_q;

    // Pick the start and stop strobes for the current mode
    always_comb begin
        unique case (win_mode_e'(mode))
            WIN_RUN:  begin start_raw = run_start; stop_raw = brk;   end
            WIN_C1C2: begin start_raw = cond1;     stop_raw = cond2; end
            WIN_C2C1: begin start_raw = cond2;     stop_raw = cond1; end
            default:  begin start_raw = 1'b0;      stop_raw = 1'b0;  end
        endcase
    end

    assign start_ok = start_raw & any_sel;

    // This cycle counts if the window is open or opens now
    assign count_en = clk_en & ~init & (open_q | start_ok);

    // Window open state and sticky configuration error
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            open_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (clk_en) begin
            open_q <= (open_q | start_ok) & ~stop_raw;
            if (start_raw && !any_sel && !open_q)
                err_q <= 1'b1;
        end
    end

    assign win_open = open_q;
    assign cfg_err  = err_q;

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !init) |=> ($stable(open_q) && $stable(err_q)));

    assert_cfg_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !init && !open_q && start_raw && !any_sel) |=> (err_q && !open_q));

    assert_same_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !init && stop_raw) |=> !open_q);

    assert_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (!open_q && !err_q));
endmodule

// File: rtl/pcu_channel.sv
// Module: one counting channel.
// Decodes the select code, weights branch hits by two, and saturates on
// overflow with a sticky flag.
// Assumes: count_en already folds in the clock enable and the window.
module pcu_channel
    import pcu_pkg::*;
#(
    parameter int unsigned CW   = 32,
    parameter int unsigned NEV  = 8,
    parameter int unsigned SELW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init,
    input  logic            count_en,
    input  logic [SELW-1:0] sel,
    input  logic [NEV-1:0]  events,
    output logic [CW-1:0]   cnt,
    output logic            ovf,
    output logic            valid
);
    logic          hit;
    logic [CW:0]   step_w;
    logic [CW:0]   sum_w;
    logic [CW-1:0] cnt_q;
    logic          ovf_q;

    // Decode the select code into a single event hit
    always_comb begin
        hit   = 1'b0;
        valid = 1'b0;
        for (int i = 0; i < int'(NEV); i++) begin
            if (sel == SELW'(i + 1)) begin
                hit   = events[i];
                valid = 1'b1;
            end
        end
    end

    // Weight branch hits by two, others by one
    assign step_w = (sel == SELW'(BRANCH_CODE)) ? (CW+1)'(2) : (CW+1)'(1);
    assign sum_w  = {1'b0, cnt_q} + step_w;

    // Counter with saturation and sticky overflow
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (count_en && hit && !ovf_q) begin
            if (sum_w[CW]) begin
                cnt_q <= '1;
                ovf_q <= 1'b1;
            end else begin
                cnt_q <= sum_w[CW-1:0];
            end
        end
    end

    assign cnt = cnt_q;
    assign ovf = ovf_q;

    assert_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !init) |=> $stable(cnt_q));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !init |=> ((cnt_q >= $past(cnt_q)) && ((cnt_q - $past(cnt_q)) <= CW'(2))));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !init) |=> (ovf_q && (cnt_q == {CW{1'b1}})));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (cnt_q == '0 && !ovf_q));
endmodule

// File: rtl/pcu_readmux.sv
// Module: read port decoder for counters and the flag word.
// Assumes: CW is at least NCH+2 so the flag word fits.
module pcu_readmux #(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 32,
    parameter int unsigned RAW = 3
) (
    input  logic [NCH*CW-1:0] cnt_flat,
    input  logic [NCH-1:0]    ovf,
    input  logic              win_open,
    input  logic              cfg_err,
    input  logic [RAW-1:0]    rd_addr,
    output logic [CW-1:0]     rd_data
);
    // Select a counter or the flag word by address
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < int'(NCH); i++) begin
            if (rd_addr == RAW'(i))
                rd_data = cnt_flat[i*CW +: CW];
        end
        if (rd_addr == RAW'(NCH))
            rd_data = CW'({cfg_err, win_open, ovf});
    end
endmodule

// File: rtl/perf_count_unit.sv
// Module: top of the event-gated performance counter unit.
// Instantiates the window controller, NCH channels and the read decoder.
// Assumes: all inputs are synchronous to clk.
module perf_count_unit
    import pcu_pkg::*;
#(
    parameter int unsigned NCH  = 4,
    parameter int unsigned CW   = 32,
    parameter int unsigned NEV  = 8,
    localparam int unsigned SELW = $clog2(NEV + 1),
    localparam int unsigned RAW  = $clog2(NCH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic                init,
    input  logic [1:0]          mode,
    input  logic                run_start,
    input  logic                brk,
    input  logic                cond1,
    input  logic                cond2,
    input  logic [NEV-1:0]      events,
    input  logic [NCH*SELW-1:0] sel,
    input  logic [RAW-1:0]      rd_addr,
    output logic [CW-1:0]       rd_data
);
    logic              count_en, win_open, cfg_err, any_sel;
    logic [NCH-1:0]    valid_v, ovf_v;
    logic [NCH*CW-1:0] cnt_flat;

    assign any_sel = |valid_v;

    pcu_window u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .init      (init),
        .mode      (mode),
        .run_start (run_start),
        .brk       (brk),
        .cond1     (cond1),
        .cond2     (cond2),
        .any_sel   (any_sel),
        .count_en  (count_en),
        .win_open  (win_open),
        .cfg_err   (cfg_err)
    );

    for (genvar g = 0; g < int'(NCH); g++) begin : g_ch
        pcu_channel #(.CW(CW), .NEV(NEV), .SELW(SELW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .init     (init),
            .count_en (count_en),
            .sel      (sel[g*SELW +: SELW]),
            .events   (events),
            .cnt      (cnt_flat[g*CW +: CW]),
            .ovf      (ovf_v[g]),
            .valid    (valid_v[g])
        );
    end

    pcu_readmux #(.NCH(NCH), .CW(CW), .RAW(RAW)) u_rd (
        .cnt_flat (cnt_flat),
        .ovf      (ovf_v),
        .win_open (win_open),
        .cfg_err  (cfg_err),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    assert_mode_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && !win_open) |=> !win_open);
endmodule

// File: tb/perf_count_unit_test.sv
module perf_count_unit_test;
    localparam int NCH = 4, CW = 8, NEV = 6;
    localparam int SELW = $clog2(NEV + 1);
    localparam int RAW  = $clog2(NCH + 1);
    localparam int WIN_BIT = 16, ERR_BIT = 32;

    logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b1, init = 1'b0;
    logic [1:0] mode = 2'd0;
    logic run_start = 0, brk = 0, cond1 = 0, cond2 = 0;
    logic [NEV-1:0] events = '0;
    logic [NCH*SELW-1:0] sel = '0;
    logic [RAW-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;

    int checks = 0, errors = 0;
    bit finished = 0;
    int    q_addr[$];
    int    q_exp[$];
    string q_tag[$];

    always #4 clk = ~clk;

    perf_count_unit #(.NCH(NCH), .CW(CW), .NEV(NEV)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .init(init), .mode(mode),
        .run_start(run_start), .brk(brk), .cond1(cond1), .cond2(cond2),
        .events(events), .sel(sel), .rd_addr(rd_addr), .rd_data(rd_data));

    // Monitor: pops expected reads and compares against the port
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_addr.size() > 0) begin
                int a, e;
                string t;
                a = q_addr.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                checks++;
                if (int'(rd_data) !== e) begin
                    errors++;
                    $display("FAIL %s addr=%0d actual=%0d expected=%0d", t, a, rd_data, e);
                end
            end
        end
    end

    // Driver: one stimulus cycle, pulses cleared afterwards
    task automatic cyc(input logic [NEV-1:0] ev, input logic rs, input logic bk,
                       input logic c1, input logic c2);
        events = ev; run_start = rs; brk = bk; cond1 = c1; cond2 = c2;
        @(negedge clk);
        events = '0; run_start = 0; brk = 0; cond1 = 0; cond2 = 0;
    endtask

    task automatic chk(input int a, input int e, input string t);
        rd_addr = RAW'(a);
        q_addr.push_back(a);
        q_exp.push_back(e);
        q_tag.push_back(t);
        @(negedge clk);
    endtask

    task automatic do_init();
        init = 1;
        cyc('0, 0, 0, 0, 0);
        init = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8 reset state
        for (int i = 0; i < NCH; i++) chk(i, 0, "R8_reset_cnt");
        chk(NCH, 0, "R8_reset_flags");

        // R9 start with no valid channel
        sel = '0;
        cyc(6'h3F, 1, 0, 0, 0);
        chk(NCH, ERR_BIT, "R9_cfg_err");
        do_init();
        chk(NCH, 0, "R8_init_clears_err");

        // R1 R2 R5: ch0 branch, ch1 line 1, ch2 off, ch3 code 7 out of range
        sel = {3'd7, 3'd0, 3'd2, 3'd1};
        mode = 2'd0;
        cyc(6'h3F, 0, 0, 0, 0);
        cyc(6'h3F, 1, 0, 0, 0);
        repeat (3) cyc(6'h3F, 0, 0, 0, 0);
        cyc(6'h3F, 0, 1, 0, 0);
        cyc(6'h3F, 0, 0, 0, 0);
        chk(0, 10, "R5_branch_weight");
        chk(1, 5, "R2_run_window");
        chk(2, 0, "R1_code0");
        chk(3, 0, "R1_code_out_of_range");
        chk(NCH, 0, "R2_closed");
        do_init();

        // R3 cond1 -> cond2
        mode = 2'd1;
        cyc(6'h3F, 0, 0, 0, 1);
        cyc(6'h3F, 0, 0, 1, 0);
        chk(NCH, WIN_BIT, "R3_open");
        repeat (2) cyc(6'h3F, 0, 0, 0, 0);
        cyc(6'h3F, 0, 0, 0, 1);
        cyc(6'h3F, 0, 0, 0, 0);
        chk(0, 8, "R3_c1c2_ch0");
        chk(1, 4, "R3_c1c2_ch1");
        do_init();

        // R4 cond2 -> cond1
        mode = 2'd2;
        cyc(6'h3F, 0, 0, 1, 0);
        cyc(6'h3F, 0, 0, 0, 1);
        cyc(6'h3F, 0, 0, 1, 0);
        cyc(6'h3F, 0, 0, 0, 0);
        chk(0, 4, "R4_c2c1_ch0");
        chk(1, 2, "R4_c2c1_ch1");
        chk(NCH, 0, "R4_closed");
        do_init();

        // R10 start and stop together
        mode = 2'd0;
        cyc(6'h3F, 1, 1, 0, 0);
        cyc(6'h3F, 0, 0, 0, 0);
        chk(0, 2, "R10_one_cycle_ch0");
        chk(1, 1, "R10_one_cycle_ch1");
        chk(NCH, 0, "R10_closed");
        do_init();

        // R7 clock stopped
        cyc(6'h3F, 1, 0, 0, 0);
        clk_en = 0;
        repeat (3) cyc(6'h3F, 0, 0, 0, 0);
        cyc(6'h3F, 0, 1, 0, 0);
        chk(1, 1, "R7_frozen_cnt");
        chk(NCH, WIN_BIT, "R7_frozen_window");
        clk_en = 1;
        cyc(6'h3F, 0, 0, 0, 0);
        chk(0, 4, "R7_resume_ch0");
        chk(1, 2, "R7_resume_ch1");
        cyc('0, 0, 1, 0, 0);
        do_init();

        // R6 saturation with sticky flag
        cyc(6'h01, 1, 0, 0, 0);
        repeat (126) cyc(6'h01, 0, 0, 0, 0);
        chk(0, 254, "R6_below_max");
        chk(NCH, WIN_BIT, "R6_no_flag_yet");
        cyc(6'h01, 0, 0, 0, 0);
        chk(0, 255, "R6_saturated");
        chk(NCH, WIN_BIT + 1, "R6_flag_set");
        repeat (3) cyc(6'h01, 0, 0, 0, 0);
        chk(0, 255, "R6_held");
        chk(NCH, WIN_BIT + 1, "R6_flag_sticky");
        // R8 init wins over counting in an open window
        init = 1;
        cyc(6'h3F, 0, 0, 0, 0);
        init = 0;
        chk(0, 0, "R8_init_priority");
        chk(NCH, 0, "R8_init_flags");

        // R11 unused addresses
        chk(5, 0, "R11_addr5");
        chk(6, 0, "R11_addr6");
        chk(7, 0, "R11_addr7");

        // R12 mode 3 never opens
        mode = 2'd3;
        cyc(6'h3F, 1, 0, 1, 1);
        cyc(6'h3F, 0, 0, 1, 0);
        chk(0, 0, "R12_off_cnt");
        chk(NCH, 0, "R12_off_window");

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule